// File: doc/BRIEF.md
# Programmable Base/Mask Chip-Select Unit

This unit turns a 32-bit bus address into one of eight active-low chip selects. The region each channel answers to is set at run time rather than fixed in logic. Every channel holds a 16-bit base value, a 16-bit mask value and an enable bit. A mask bit of one makes the matching address bit a don't-care. This lets a channel cover any aligned power-of-two window of 64 KB or more.

Software programs the channels through a write port. Each write carries a channel index, a register selector and 16 data bits. A separate read port returns any register one cycle later. On every clock, the address is compared against all enabled channels. If the bus strobe is high, a registered select vector is produced in which at most one line is low. When more than one enabled channel claims the same address, the lowest-numbered channel wins, so the selects never fight on the data bus. An overlap flag is raised for that cycle.

Top module: `csel_unit`

## Requirements
- R1: After reset, every channel is disabled and its base and mask read as 0x0000, `cs_no` is all ones and `overlap_o` is 0.
- R2: A write with `wr_en_i` high updates the selected register at the clock edge. Register selector encoding: 0 = base, 1 = mask, 2 = control, 3 = reserved. A reserved write changes nothing, and a reserved read returns 0x0000. An address presented in the same cycle as a write is decoded with the old settings; from the next cycle on, the new settings apply.
- R3: A channel matches when, for every bit i (0..15) whose mask bit is 0, address bit 16+i equals base bit i. Address bits 15..0 never take part.
- R4: A mask bit of 1 excludes that base bit. With base 0x4000 and mask 0x0003, the channel matches 0x4000_0000 through 0x4003_FFFF and does not match 0x4004_0000 or 0x3FFF_FFFF.
- R5: A channel whose enable bit is 0 never drives its select low.
- R6: If `valid_i` is low in a cycle, then after the next edge `cs_no` is all ones and `overlap_o` is 0.
- R7: `cs_no` and `overlap_o` reflect the address and strobe sampled at the previous edge. Bit n of `cs_no` is low only for the selected channel n, and at most one bit is low.
- R8: When two or more enabled channels match while `valid_i` is high, only the lowest-numbered of them is selected and `overlap_o` is 1 for that cycle.
- R9: Control register bit 0 is the channel enable, and the other data bits are ignored. A control read returns the enable in bit 0 and zeros elsewhere. `rd_data_o` shows the register named by `rd_ch_i`/`rd_sel_i` one cycle after they are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Bus address |
| valid_i | input | 1 | Bus strobe; selects only while high |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | 3 | Channel index for the write |
| wr_sel_i | input | 2 | Register selector for the write |
| wr_data_i | input | 16 | Write data |
| rd_ch_i | input | 3 | Channel index for read-back |
| rd_sel_i | input | 2 | Register selector for read-back |
| rd_data_o | output | 16 | Registered read-back data |
| cs_no | output | 8 | Active-low chip selects, at most one low |
| overlap_o | output | 1 | More than one enabled channel matched |

## Verification
The assertions assume that reset is applied before the first decode and that `wr_ch_i` and `rd_ch_i` always name an existing channel. The bench drives indices only in 0..7. The bench deliberately provokes overlapping channels and writes that collide with a decode in the same cycle. Random phases keep the base values and the address upper half inside a small range (0x4000..0x4007), so that hits, misses and overlaps all occur often.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [1:0] {
    REG_BASE = 2'd0,
    REG_MASK = 2'd1,
    REG_CTRL = 2'd2,
    REG_RSVD = 2'd3
  } csel_reg_e;
endpackage

// File: rtl/csel_regfile.sv
module csel_regfile #(
  parameter int NUM_CH = 8,
  parameter int CMP_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [CH_W-1:0]              wr_ch_i,
  input  logic [1:0]                   wr_sel_i,
  input  logic [CMP_W-1:0]             wr_data_i,
  input  logic [CH_W-1:0]              rd_ch_i,
  input  logic [1:0]                   rd_sel_i,
  output logic [CMP_W-1:0]             rd_data_o,
  output logic [NUM_CH-1:0][CMP_W-1:0] base_o,
  output logic [NUM_CH-1:0][CMP_W-1:0] mask_o,
  output logic [NUM_CH-1:0]            en_o
);
  import csel_pkg::*;

  csel_reg_e wsel, rsel;
  logic [CMP_W-1:0] rd_d;

  assign wsel = csel_reg_e'(wr_sel_i);
  assign rsel = csel_reg_e'(rd_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      mask_o <= '0;
      en_o   <= '0;
    end else if (wr_en_i) begin
      unique case (wsel)
        REG_BASE: base_o[wr_ch_i] <= wr_data_i;
        REG_MASK: mask_o[wr_ch_i] <= wr_data_i;
        REG_CTRL: en_o[wr_ch_i]   <= wr_data_i[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (rsel)
      REG_BASE: rd_d = base_o[rd_ch_i];
      REG_MASK: rd_d = mask_o[rd_ch_i];
      REG_CTRL: rd_d = {{(CMP_W-1){1'b0}}, en_o[rd_ch_i]};
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_d;
  end
endmodule

// File: rtl/csel_match.sv
module csel_match #(
  parameter int NUM_CH = 8,
  parameter int CMP_W  = 16
) (
  input  logic [CMP_W-1:0]             addr_hi_i,
  input  logic [NUM_CH-1:0][CMP_W-1:0] base_i,
  input  logic [NUM_CH-1:0][CMP_W-1:0] mask_i,
  input  logic [NUM_CH-1:0]            en_i,
  output logic [NUM_CH-1:0]            hit_o
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    // mask bit 1 = don't care
    assign hit_o[n] = en_i[n] && (((addr_hi_i ^ base_i[n]) & ~mask_i[n]) == '0);
  end
endmodule

// File: rtl/csel_prio.sv
module csel_prio #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] hit_i,
  output logic [NUM_CH-1:0] win_o,
  output logic              multi_o
);
  // isolate lowest set bit; more than one bit if clearing it leaves any
  assign win_o   = hit_i & (~hit_i + NUM_CH'(1));
  assign multi_o = (hit_i & (hit_i - NUM_CH'(1))) != '0;
endmodule

// File: rtl/csel_unit.sv
module csel_unit #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32,
  parameter int CMP_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              valid_i,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [CMP_W-1:0]  wr_data_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  input  logic [1:0]        rd_sel_i,
  output logic [CMP_W-1:0]  rd_data_o,
  output logic [NUM_CH-1:0] cs_no,
  output logic              overlap_o
);
  logic [NUM_CH-1:0][CMP_W-1:0] base, mask;
  logic [NUM_CH-1:0] en, hit, win;
  logic multi;

  csel_regfile #(.NUM_CH(NUM_CH), .CMP_W(CMP_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_ch_i, .wr_sel_i, .wr_data_i,
    .rd_ch_i, .rd_sel_i, .rd_data_o,
    .base_o(base), .mask_o(mask), .en_o(en)
  );

  csel_match #(.NUM_CH(NUM_CH), .CMP_W(CMP_W)) u_match (
    .addr_hi_i(addr_i[ADDR_W-1 -: CMP_W]),
    .base_i(base), .mask_i(mask), .en_i(en), .hit_o(hit)
  );

  csel_prio #(.NUM_CH(NUM_CH)) u_prio (
    .hit_i(hit), .win_o(win), .multi_o(multi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_no     <= '1;
      overlap_o <= 1'b0;
    end else begin
      cs_no     <= valid_i ? ~win : '1;
      overlap_o <= valid_i && multi;
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no)); // R7
  AST_IDLE_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (cs_no == '1) && !overlap_o); // R6
  AST_OVERLAP_HAS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overlap_o |-> (cs_no != '1)); // R8
  AST_DISABLED_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~cs_no & ~$past(en)) == '0)); // R5
endmodule

// File: tb/sim_csel_unit.sv
module sim_csel_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        valid = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_ch = '0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_ch = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic [7:0]  cs_n;
  logic        ovl;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] m_base [8];
  logic [15:0] m_mask [8];
  bit          m_en   [8];
  logic [7:0]  exp_cs = 8'hFF;
  bit          exp_ov = 1'b0;
  logic [15:0] exp_rd = '0;
  string       exp_tag = "R1";

  always #5 clk = ~clk;

  csel_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .valid_i(valid),
    .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_ch_i(rd_ch), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .cs_no(cs_n), .overlap_o(ovl)
  );

  task automatic check_outputs();
    n_tests += 3;
    if (cs_n !== exp_cs) begin
      n_fail++;
      $display("FAIL %s cs_no: got %h exp %h", exp_tag, cs_n, exp_cs);
    end
    if (ovl !== exp_ov) begin
      n_fail++;
      $display("FAIL %s overlap: got %b exp %b", exp_tag, ovl, exp_ov);
    end
    if (rd_data !== exp_rd) begin
      n_fail++;
      $display("FAIL %s rd_data: got %h exp %h", exp_tag, rd_data, exp_rd);
    end
  endtask

  // one cycle: check previous result, drive new inputs, predict next result
  task automatic step(input logic [31:0] a, input bit v, input bit we,
                      input int ch, input int sel, input logic [15:0] d,
                      input int rch, input int rsel, input string tag);
    int cnt;
    int first;
    @(negedge clk);
    check_outputs();
    addr = a; valid = v; wr_en = we; wr_ch = 3'(ch); wr_sel = 2'(sel);
    wr_data = d; rd_ch = 3'(rch); rd_sel = 2'(rsel);
    cnt = 0; first = -1;
    for (int n = 0; n < 8; n++) begin
      if (m_en[n] && (((a[31:16] ^ m_base[n]) & ~m_mask[n]) == 16'h0)) begin
        cnt++;
        if (first < 0) first = n;
      end
    end
    exp_cs = 8'hFF;
    if (v && first >= 0) exp_cs[first] = 1'b0;
    exp_ov = v && (cnt >= 2);
    case (rsel)
      0: exp_rd = m_base[rch];
      1: exp_rd = m_mask[rch];
      2: exp_rd = {15'h0, m_en[rch]};
      default: exp_rd = 16'h0;
    endcase
    exp_tag = tag;
    if (we) begin
      case (sel)
        0: m_base[ch] = d;
        1: m_mask[ch] = d;
        2: m_en[ch]   = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [15:0] d, input string tag);
    step(32'h0, 1'b0, 1'b1, ch, sel, d, ch, sel, tag);
  endtask

  task automatic probe(input logic [31:0] a, input string tag);
    step(a, 1'b1, 1'b0, 0, 0, 16'h0, 2, 2, tag);
  endtask

  initial begin
    for (int n = 0; n < 8; n++) begin
      m_base[n] = '0; m_mask[n] = '0; m_en[n] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset read-back of every register
    for (int n = 0; n < 8; n++)
      for (int s = 0; s < 3; s++)
        step(32'h0, 1'b0, 1'b0, 0, 0, 16'h0, n, s, "R1");
    probe(32'h0000_0000, "R1");

    // R5: programmed but disabled channel stays silent
    wr(2, 0, 16'h4000, "R2");
    wr(2, 1, 16'h0003, "R2");
    probe(32'h4000_1234, "R5");

    // R9: enable is data bit 0 only
    wr(2, 2, 16'hFFFE, "R9");
    probe(32'h4000_0000, "R9");
    wr(2, 2, 16'h0001, "R9");

    // R3/R4: window boundaries for base 0x4000 mask 0x0003
    probe(32'h4000_0000, "R4");
    probe(32'h4003_FFFF, "R4");
    probe(32'h4004_0000, "R4");
    probe(32'h3FFF_FFFF, "R4");
    probe(32'h4002_ABCD, "R3");

    // R6: strobe low blocks a hit
    step(32'h4001_0000, 1'b0, 1'b0, 0, 0, 16'h0, 2, 2, "R6");

    // R8: overlapping channels 5 and 0
    wr(5, 0, 16'h4001, "R2");
    wr(5, 2, 16'h0001, "R2");
    probe(32'h4001_0000, "R8");
    wr(0, 0, 16'h4001, "R2");
    wr(0, 2, 16'h0001, "R2");
    probe(32'h4001_FFFF, "R8");
    probe(32'h4003_0000, "R7");

    // R2: reserved selector ignored and reads zero
    wr(3, 3, 16'hFFFF, "R2");
    step(32'h0, 1'b0, 1'b0, 0, 0, 16'h0, 3, 3, "R2");
    step(32'h0, 1'b0, 1'b0, 0, 0, 16'h0, 3, 0, "R2");
    step(32'h0, 1'b0, 1'b0, 0, 0, 16'h0, 3, 1, "R2");

    // R2: write in the same cycle as a decode applies only afterwards
    wr(7, 0, 16'h7777, "R2");
    step(32'h7777_0000, 1'b1, 1'b1, 7, 2, 16'h0001, 7, 2, "R2");
    probe(32'h7777_0000, "R2");

    // R7/R8: random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = {16'h4000 | 16'($urandom_range(0, 7)), 16'($urandom)};
      if ($urandom_range(0, 3) == 0)
        step(a, 1'($urandom), 1'b1, $urandom_range(0, 7), $urandom_range(0, 3),
             ($urandom_range(0, 1) == 1) ? (16'h4000 | 16'($urandom_range(0, 7)))
                                         : 16'($urandom_range(0, 7)),
             $urandom_range(0, 7), $urandom_range(0, 3), "R8");
      else
        step(a, 1'($urandom), 1'b0, 0, 0, 16'h0,
             $urandom_range(0, 7), $urandom_range(0, 3), "R7");
    end
    step(32'h0, 1'b0, 1'b0, 0, 0, 16'h0, 0, 0, "R6");
    @(negedge clk);
    check_outputs();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule